// File: doc/BRIEF.md
# I2C-over-AUX EDID Responder

This block answers I2C-over-AUX requests that host software issues through a small register window. It holds a 128-byte EDID image and serves it one byte per request. To read the image, software follows a fixed sequence. It writes a request header into the first data register. It then writes the control register with the send-busy bit set. In the same clock edge the block decodes the request, updates its slave selection and byte pointer, and posts a reply in the control register and the first data register.

A request with message length 3 carries an address only. It opens or closes the slave session. A request with message length 4 and a read opcode fetches one byte. The middle-of-transaction bit lets consecutive requests share one selection, so a host can stream the whole image by repeating the read request. I2C writes receive an acknowledge and change no state.

Top module: `aux_edid_responder`

## Requirements
- R1: A synchronous reset clears the control register and every data register to 0. It also clears the slave selection, the EDID-available flag, the byte pointer and `edidPort`.
- R2: A write at offset 0x14, 0x18, 0x1C, 0x20 or 0x24 (data registers 1 to 5) is stored and reads back unchanged. Offsets outside these five and 0x10 read as 0, and writes to them have no effect.
- R3: A write to the control register (0x10) with bit 31 (send-busy) clear changes neither the control register nor data register 1.
- R4: A control write with send-busy set makes control equal to bit 30 (done) plus a reply size in bits 24:20. The size is 2 when header bit 28 (opcode bit 0, the read flag) is 1, and 1 otherwise. The header is data register 1: opcode in bits 31:28, I2C address in bits 23:8. The request length is taken from the written control bits 24:20.
- R5: A length-3 request with header bit 30 (MOT) set and address 0x0050 selects the slave and records `portIdx` on `edidPort`. It marks EDID available when `monitorPresent` is 1, and the byte pointer is kept. A length-3 request with MOT set and any other non-zero address changes no state. Every length-3 request leaves data register 1 equal to 0.
- R6: A length-3 request with MOT clear, or with MOT set and address 0, clears the selection, the available flag, the pointer and `edidPort`.
- R7: A length-4 read while the slave is selected and EDID is available puts image byte P in bits 23:16 of data register 1 and advances P. Bits 31:24 hold the acknowledge code 0x00 and the other bits are 0. The image byte is ((P*29) mod 256) XOR 0xA5.
- R8: A length-4 read while no slave is selected or EDID is not available returns 0xFF in bits 23:16 and leaves the pointer unchanged.
- R9: Once all 128 bytes have been read, each further read returns byte value 0 and the pointer stays at 128.
- R10: A request with read flag 0 and length other than 3 sets data register 1 to 0 (acknowledge code 0x00) and changes no state.
- R11: A request with read flag 1 and length other than 3 or 4 updates control as in R4. It leaves data register 1 and the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Low offset byte of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Low offset byte of the read |
| rdData | output | 32 | Combinational read data |
| monitorPresent | input | 1 | A display is attached to the port |
| portIdx | input | PORT_W | Port number recorded on selection |
| edidPort | output | PORT_W | Port recorded by the last selection |

## Verification
The assertions assume that a write and the request it issues reach the block one per cycle. They assume that software has written data register 1 in an earlier cycle than the control write that consumes it, since the header is sampled from the stored register. They also assume that reset is held from time zero until the first clock edge. The bench keeps within these assumptions by driving every register write as its own single-cycle strobe, with an idle cycle between writes. It always loads the header before issuing the control write, and it holds reset over several edges at start.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h10;
  localparam logic [7:0] OFS_DATA0 = 8'h14;
  localparam int         OFS_STEP  = 4;

  localparam logic [4:0] LEN_ADDR_ONLY = 5'd3;
  localparam logic [4:0] LEN_READ      = 5'd4;

  localparam logic [7:0] REPLY_ACK = 8'h00;
  localparam int         DONE_BIT  = 30;
  localparam int         SIZE_LSB  = 20;

  localparam int OP_READ_BIT = 0;
  localparam int OP_MOT_BIT  = 2;

  typedef struct packed {
    logic reply;
    logic replyRead;
    logic loadReply;
    logic clearState;
    logic selectSlave;
    logic fetchByte;
  } strobe_t;

  function automatic logic [7:0] romByte(input logic [15:0] idx);
    logic [15:0] prod;
    prod = idx * 16'd29;
    return prod[7:0] ^ 8'hA5;
  endfunction

endpackage

// File: rtl/aux_edid_ctrl.sv
module aux_edid_ctrl
  import aux_edid_pkg::*;
#(
  parameter int          NUM_DATA  = 5,
  parameter logic [15:0] EDID_ADDR = 16'h0050
) (
  input  logic                wrEn,
  input  logic [7:0]          wrAddr,
  input  logic                sendBusy,
  input  logic [4:0]          msgLen,
  input  logic [3:0]          opcode,
  input  logic [15:0]         i2cAddr,
  output strobe_t             stb,
  output logic [NUM_DATA-1:0] dataWe
);

  logic ctrlHit;
  logic isRead;
  logic isMot;

  assign ctrlHit = wrEn && (wrAddr == OFS_CTRL);
  assign isRead  = opcode[OP_READ_BIT];
  assign isMot   = opcode[OP_MOT_BIT];

  always_comb begin
    for (int i = 0; i < NUM_DATA; i++) begin
      dataWe[i] = wrEn && (wrAddr == (OFS_DATA0 + 8'(OFS_STEP * i)));
    end
  end

  always_comb begin
    stb = '0;
    if (ctrlHit && sendBusy) begin
      stb.reply     = 1'b1;
      stb.replyRead = isRead;
      if (msgLen == LEN_ADDR_ONLY) begin
        stb.loadReply = 1'b1;
        if (!isMot) begin
          stb.clearState = 1'b1;
        end else if (i2cAddr == 16'h0000) begin
          stb.clearState = 1'b1;
        end else if (i2cAddr == EDID_ADDR) begin
          stb.selectSlave = 1'b1;
        end
      end else if (!isRead) begin
        stb.loadReply = 1'b1;
      end else if (msgLen == LEN_READ) begin
        stb.loadReply = 1'b1;
        stb.fetchByte = 1'b1;
      end
    end
  end

endmodule

// File: rtl/aux_edid_regs.sv
module aux_edid_regs
  import aux_edid_pkg::*;
#(
  parameter int EDID_BYTES = 128,
  parameter int NUM_DATA   = 5,
  parameter int PORT_W     = 3,
  parameter int PTR_W      = $clog2(EDID_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [31:0]         wrData,
  input  strobe_t             stb,
  input  logic [NUM_DATA-1:0] dataWe,
  input  logic                monitorPresent,
  input  logic [PORT_W-1:0]   portIdx,
  input  logic [7:0]          rdAddr,
  output logic [31:0]         rdData,
  output logic [31:0]         ctrlQ,
  output logic [31:0]         data1Q,
  output logic [PTR_W-1:0]    ptrQ,
  output logic [PORT_W-1:0]   edidPort
);

  logic [31:0] dataQ [NUM_DATA];
  logic        slaveSel;
  logic        edidAvail;
  logic        inRange;
  logic [7:0]  nextByte;
  logic [7:0]  replyByte;
  logic [31:0] replyWord;
  logic [4:0]  replySize;

  assign inRange   = ptrQ < PTR_W'(EDID_BYTES);
  assign nextByte  = inRange ? romByte(16'(ptrQ)) : 8'h00;
  assign replyByte = (slaveSel && edidAvail) ? nextByte : 8'hFF;
  assign replyWord = stb.fetchByte ? {REPLY_ACK, replyByte, 16'h0000}
                                   : {REPLY_ACK, 24'h000000};
  assign replySize = stb.replyRead ? 5'd2 : 5'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ <= '0;
    end else if (stb.reply) begin
      ctrlQ <= (32'd1 << DONE_BIT) | (32'(replySize) << SIZE_LSB);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_DATA; i++) dataQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_DATA; i++) begin
        if (dataWe[i]) begin
          dataQ[i] <= wrData;
        end else if (i == 0 && stb.loadReply) begin
          dataQ[i] <= replyWord;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stb.clearState) begin
      slaveSel  <= 1'b0;
      edidAvail <= 1'b0;
      ptrQ      <= '0;
      edidPort  <= '0;
    end else if (stb.selectSlave) begin
      slaveSel <= 1'b1;
      edidPort <= portIdx;
      if (monitorPresent) edidAvail <= 1'b1;
    end else if (stb.fetchByte && slaveSel && edidAvail && inRange) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  assign data1Q = dataQ[0];

  always_comb begin
    rdData = '0;
    if (rdAddr == OFS_CTRL) rdData = ctrlQ;
    for (int i = 0; i < NUM_DATA; i++) begin
      if (rdAddr == (OFS_DATA0 + 8'(OFS_STEP * i))) rdData = dataQ[i];
    end
  end

endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder
  import aux_edid_pkg::*;
#(
  parameter int          EDID_BYTES = 128,
  parameter int          NUM_DATA   = 5,
  parameter int          PORT_W     = 3,
  parameter logic [15:0] EDID_ADDR  = 16'h0050
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [7:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic [7:0]        rdAddr,
  output logic [31:0]       rdData,
  input  logic              monitorPresent,
  input  logic [PORT_W-1:0] portIdx,
  output logic [PORT_W-1:0] edidPort
);

  localparam int PTR_W = $clog2(EDID_BYTES + 1);

  strobe_t             stb;
  logic [NUM_DATA-1:0] dataWe;
  logic [31:0]         ctrlQ;
  logic [31:0]         data1Q;
  logic [PTR_W-1:0]    ptrQ;

  aux_edid_ctrl #(
    .NUM_DATA (NUM_DATA),
    .EDID_ADDR(EDID_ADDR)
  ) i_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .sendBusy(wrData[31]),
    .msgLen  (wrData[24:20]),
    .opcode  (data1Q[31:28]),
    .i2cAddr (data1Q[23:8]),
    .stb     (stb),
    .dataWe  (dataWe)
  );

  aux_edid_regs #(
    .EDID_BYTES(EDID_BYTES),
    .NUM_DATA  (NUM_DATA),
    .PORT_W    (PORT_W),
    .PTR_W     (PTR_W)
  ) i_regs (
    .clk           (clk),
    .rst           (rst),
    .wrData        (wrData),
    .stb           (stb),
    .dataWe        (dataWe),
    .monitorPresent(monitorPresent),
    .portIdx       (portIdx),
    .rdAddr        (rdAddr),
    .rdData        (rdData),
    .ctrlQ         (ctrlQ),
    .data1Q        (data1Q),
    .ptrQ          (ptrQ),
    .edidPort      (edidPort)
  );

endmodule

// File: rtl/aux_edid_chk.sv
module aux_edid_chk #(
  parameter int EDID_BYTES = 128,
  parameter int PTR_W      = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic [7:0]       wrAddr,
  input logic [31:0]      wrData,
  input logic [31:0]      ctrlQ,
  input logic [31:0]      data1Q,
  input logic [PTR_W-1:0] ptrQ
);

  // R3
  idle_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 8'h10 && !wrData[31]) |=> ($stable(ctrlQ) && $stable(data1Q)));

  // R4
  done_reply_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 8'h10 && wrData[31]) |=>
      (ctrlQ[30] && ctrlQ[24:20] == ($past(data1Q[28]) ? 5'd2 : 5'd1)));

  // R2
  data_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 8'h14) |=> (data1Q == $past(wrData)));

  // R9
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ptrQ <= PTR_W'(EDID_BYTES));

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptrQ) |-> (ptrQ == '0 || ptrQ == PTR_W'($past(ptrQ) + 1'b1)));

endmodule

bind aux_edid_responder aux_edid_chk #(
  .EDID_BYTES(EDID_BYTES),
  .PTR_W     (PTR_W)
) i_chk (
  .clk   (clk),
  .rst   (rst),
  .wrEn  (wrEn),
  .wrAddr(wrAddr),
  .wrData(wrData),
  .ctrlQ (ctrlQ),
  .data1Q(data1Q),
  .ptrQ  (ptrQ)
);

// File: tb/test_aux_edid_responder.sv
`timescale 1ns/100ps
module test_aux_edid_responder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        monitorPresent = 1'b1;
  logic [2:0]  portIdx = 3'd2;
  logic [2:0]  edidPort;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  bit          selQ[$];
  string       tagQ[$];

  localparam logic [31:0] HDR_START = 32'h4000_5000;
  localparam logic [31:0] HDR_READ  = 32'h5000_5000;
  localparam logic [31:0] HDR_STOP  = 32'h0000_5000;
  localparam logic [31:0] CTL_LEN3  = 32'h8030_0000;
  localparam logic [31:0] CTL_LEN4  = 32'h8040_0000;
  localparam logic [31:0] CTL_LEN1  = 32'h8010_0000;

  always #2.5 clk = ~clk;

  aux_edid_responder i_aux_edid_responder (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .monitorPresent(monitorPresent),
    .portIdx(portIdx), .edidPort(edidPort)
  );

  function automatic logic [7:0] imgByte(input int p);
    return 8'((p * 29) % 256) ^ 8'hA5;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic expectReg(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    rdAddr = a;
    expQ.push_back(e); selQ.push_back(1'b0); tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic expectPort(input logic [2:0] e, input string tag);
    @(posedge clk); #1;
    expQ.push_back(32'(e)); selQ.push_back(1'b1); tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic readByte(input logic [7:0] b, input string tag);
    wr(8'h14, HDR_READ);
    wr(8'h10, CTL_LEN4);
    expectReg(8'h14, {8'h00, b, 16'h0000}, tag);
  endtask

  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [31:0] e;
      logic [31:0] act;
      bit s;
      string t;
      e = expQ.pop_front(); s = selQ.pop_front(); t = tagQ.pop_front();
      act = s ? 32'(edidPort) : rdData;
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, act, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    expectReg(8'h10, 32'h0, "R1 ctrl after reset");
    expectReg(8'h14, 32'h0, "R1 data1 after reset");
    expectPort(3'd0, "R1 port after reset");

    wr(8'h1C, 32'hDEAD_BEEF);
    expectReg(8'h1C, 32'hDEAD_BEEF, "R2 data3 store");
    wr(8'h24, 32'h0BAD_F00D);
    expectReg(8'h24, 32'h0BAD_F00D, "R2 data5 store");
    wr(8'h28, 32'h1234_5678);
    expectReg(8'h28, 32'h0, "R2 unmapped offset");
    expectReg(8'h1C, 32'hDEAD_BEEF, "R2 neighbour untouched");

    readByte(8'hFF, "R8 read before select");
    expectReg(8'h10, 32'h4020_0000, "R4 read reply ctrl");

    wr(8'h10, 32'h0040_0000);
    expectReg(8'h10, 32'h4020_0000, "R3 ctrl kept");
    expectReg(8'h14, 32'h00FF_0000, "R3 data1 kept");

    wr(8'h14, HDR_START);
    wr(8'h10, CTL_LEN3);
    expectReg(8'h10, 32'h4010_0000, "R4 address reply ctrl");
    expectReg(8'h14, 32'h0, "R5 address reply data1");
    expectPort(3'd2, "R5 port recorded");

    for (int i = 0; i < 128; i++) readByte(imgByte(i), "R7 image byte");
    readByte(8'h00, "R9 past end");
    readByte(8'h00, "R9 past end again");

    wr(8'h14, HDR_STOP);
    wr(8'h10, CTL_LEN3);
    expectPort(3'd0, "R6 port cleared by stop");
    readByte(8'hFF, "R6 read after stop");

    wr(8'h14, HDR_START);
    wr(8'h10, CTL_LEN3);
    readByte(imgByte(0), "R6 pointer restarted");
    readByte(imgByte(1), "R7 second byte");

    wr(8'h14, 32'h4000_5000);
    wr(8'h10, CTL_LEN1);
    expectReg(8'h10, 32'h4010_0000, "R10 write ack ctrl");
    expectReg(8'h14, 32'h0, "R10 write ack data1");
    readByte(imgByte(2), "R10 pointer unchanged");

    wr(8'h14, HDR_READ);
    wr(8'h10, CTL_LEN1);
    expectReg(8'h10, 32'h4020_0000, "R11 ctrl reply");
    expectReg(8'h14, HDR_READ, "R11 data1 unchanged");
    readByte(imgByte(3), "R11 pointer unchanged");

    wr(8'h14, 32'h4000_3700);
    wr(8'h10, CTL_LEN3);
    expectReg(8'h14, 32'h0, "R5 other address data1");
    readByte(imgByte(4), "R5 other address keeps selection");

    wr(8'h14, 32'h4000_0000);
    wr(8'h10, CTL_LEN3);
    readByte(8'hFF, "R6 zero address reset");

    monitorPresent = 1'b0;
    portIdx = 3'd3;
    wr(8'h14, HDR_START);
    wr(8'h10, CTL_LEN3);
    expectPort(3'd3, "R5 port without monitor");
    readByte(8'hFF, "R5 no monitor not available");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule